// File: doc/BRIEF.md
# Prescaled Reloading Tick Timer

This block produces a periodic interrupt from a slow timebase. A one-cycle enable pulse, nominally at 32.768 kHz, drives a power-of-two prescaler. Each prescaler step decrements a down-counter. When the counter expires, it reloads from a programmed value and sets a pending interrupt, so the interrupt repeats at a fixed period for as long as the timer runs.

Software reaches the block through a single-cycle register port with a combinational read path. The port gives access to a control word, the reload value, the live counter and the interrupt status. The timer starts only on a rising edge of its own enable while the block enable is also set. It stops when either enable falls. A reload value too small to be useful is refused.

Top module: `tick_timer`

## Requirements
- R1: After reset, the timer is stopped, and the control word, reload value, live count and pending bit all read 0. `tickIrq` is low.
- R2: Control bits [7:4] hold a rate select N. While running, the live count changes only on a slow-enable pulse, and it decrements once every 2^N pulses, counted from the start.
- R3: A write to the control word (address 0) starts the timer only when all of these hold: bit 0 (block enable) is 1 in the written value, bit 8 (tick enable) goes from 0 to 1, and the reload value is nonzero. A start loads the reload value into the live count and restarts the prescaler.
- R4: A control write that clears bit 8, or that clears bit 0, stops the timer. The live count then holds its value across further slow pulses.
- R5: A write to the reload register (address 1) is taken only if the written value is greater than 2. Otherwise the previous value is kept.
- R6: When a step occurs with the live count at 1, the live count reloads from the reload register, status bit 0 sets and `tickIrq` rises. The timer keeps running, so the interrupt repeats every reload-value steps.
- R7: Writing 1 to bit 0 of the status register (address 3) clears the pending bit and lowers `tickIrq`. Writing 0 has no effect.
- R8: Address 2 returns the live down-counter value and ignores writes.
- R9: Changing the rate select while running keeps the live count and the running state.
- R10: Setting block enable while tick enable is already 1 does not start the timer, because tick enable does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowEn | input | 1 | One-cycle pulse of the 32.768 kHz timebase |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 reload, 2 live count, 3 status |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| tickIrq | output | 1 | Tick interrupt, high while pending |

## Verification
The assertions check every cycle that:
- the live count moves only on a slow pulse or a control write;
- a stopped timer holds its count;
- a running timer never shows a zero count;
- a rejected reload write leaves the register unchanged;
- the interrupt rises only after a slow pulse while running;
- a clear lowers the line.

Only the bench scenarios can show the rest: the exact 2^N prescaler spacing, the reload period, the start rules on enable edges (including the zero-reload and already-set cases), and that a rate change keeps the count.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // Control word bit positions; software depends on these.
  localparam int EN_BIT   = 0;
  localparam int SEL_LSB  = 4;
  localparam int TICK_BIT = 8;
  localparam int CTRL_W   = TICK_BIT + 1;

  // Register addresses
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_LIVE   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;
    logic halt;
    logic clrPend;
  } ctrl_stb_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [CNT_W-1:0]  liveCnt,
  input  logic              pend,
  output logic [DATA_W-1:0] regRdata,
  output ctrl_stb_t         stb,
  output logic [SEL_W-1:0]  rateSel,
  output logic [CNT_W-1:0]  reloadCnt
);
  logic [CTRL_W-1:0] ctrlReg;
  logic wrCtrl, wrReload, tickRise, enFall, tickFall;

  assign wrCtrl   = regWr && (regAddr == ADDR_CTRL);
  assign wrReload = regWr && (regAddr == ADDR_RELOAD) && (regWdata > DATA_W'(2));
  assign tickRise = regWdata[TICK_BIT] && !ctrlReg[TICK_BIT];
  assign tickFall = !regWdata[TICK_BIT] && ctrlReg[TICK_BIT];
  assign enFall   = !regWdata[EN_BIT] && ctrlReg[EN_BIT];

  always_comb begin
    stb.start   = wrCtrl && regWdata[EN_BIT] && tickRise && (reloadCnt != '0);
    stb.halt    = wrCtrl && (tickFall || enFall);
    stb.clrPend = regWr && (regAddr == ADDR_STAT) && regWdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      reloadCnt <= '0;
    end else begin
      if (wrCtrl)   ctrlReg   <= regWdata[CTRL_W-1:0];
      if (wrReload) reloadCnt <= regWdata[CNT_W-1:0];
    end
  end

  assign rateSel = ctrlReg[SEL_LSB +: SEL_W];

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdata = DATA_W'(ctrlReg);
      ADDR_RELOAD: regRdata = DATA_W'(reloadCnt);
      ADDR_LIVE:   regRdata = DATA_W'(liveCnt);
      default:     regRdata = DATA_W'(pend);
    endcase
  end
endmodule

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slowEn,
  input  ctrl_stb_t        stb,
  input  logic [SEL_W-1:0] rateSel,
  input  logic [CNT_W-1:0] reloadCnt,
  output logic [CNT_W-1:0] liveCnt,
  output logic             running,
  output logic             pend
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic step, fire;

  assign preMask = PRE_W'((64'd1 << rateSel) - 64'd1);
  assign step    = running && slowEn && ((preCnt & preMask) == preMask);
  assign fire    = step && (liveCnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      liveCnt <= '0;
      preCnt  <= '0;
    end else if (stb.halt) begin
      running <= 1'b0;
    end else if (stb.start) begin
      running <= 1'b1;
      liveCnt <= reloadCnt;
      preCnt  <= '0;
    end else if (running && slowEn) begin
      preCnt <= preCnt + 1'b1;
      if (fire)      liveCnt <= reloadCnt;
      else if (step) liveCnt <= liveCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            pend <= 1'b0;
    else if (fire)        pend <= 1'b1;
    else if (stb.clrPend) pend <= 1'b0;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowEn,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              tickIrq
);
  ctrl_stb_t        stb;
  logic [SEL_W-1:0] rateSel;
  logic [CNT_W-1:0] reloadCnt;
  logic [CNT_W-1:0] liveCnt;
  logic             tmrRun;
  logic             pend;

  tick_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .liveCnt(liveCnt), .pend(pend),
    .regRdata(regRdata), .stb(stb), .rateSel(rateSel), .reloadCnt(reloadCnt)
  );

  tick_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .stb(stb), .rateSel(rateSel),
    .reloadCnt(reloadCnt), .liveCnt(liveCnt), .running(tmrRun), .pend(pend)
  );

  assign tickIrq = pend;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              slowEn,
  input logic              regWr,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              tickIrq,
  input logic [CNT_W-1:0]  liveCnt,
  input logic [CNT_W-1:0]  reloadCnt,
  input logic              tmrRun
);
  logic ctrlWr;
  assign ctrlWr = regWr && (regAddr == 2'd0);

  // R2
  count_moves_on_slow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slowEn && !ctrlWr) |=> $stable(liveCnt));

  // R4
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrRun && !ctrlWr) |=> $stable(liveCnt));

  // R4
  block_off_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !regWdata[0]) |=> !tmrRun);

  // R5
  small_reload_rejected_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd1 && regWdata <= DATA_W'(2)) |=> $stable(reloadCnt));

  // R6
  run_count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmrRun |-> (liveCnt != '0));

  // R6
  irq_rise_on_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tickIrq) |-> ($past(tmrRun) && $past(slowEn)));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 2'd3 && regWdata[0] && (!tmrRun || !slowEn)) |=> !tickIrq);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .slowEn(slowEn), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .tickIrq(tickIrq), .liveCnt(liveCnt),
  .reloadCnt(reloadCnt), .tmrRun(tmrRun)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowEn = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickIrq;

  int applied = 0;
  int errors = 0;
  logic rdStrobe = 1'b0;
  logic done = 1'b0;

  typedef struct packed {
    logic [31:0] data;
    logic        irq;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rstN(rstN), .slowEn(slowEn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .tickIrq(tickIrq)
  );

  // Monitor: compares the read port and the irq pin while a read is held.
  always @(posedge clk) begin
    if (rdStrobe && expQ.size() > 0) begin
      exp_t  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      applied++;
      if (regRdata !== e.data || tickIrq !== e.irq) begin
        errors++;
        $display("FAIL %s: addr %0d data %0h irq %0b, expected data %0h irq %0b",
                 t, regAddr, regRdata, tickIrq, e.data, e.irq);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] d,
                    input logic irq, input string tag);
    @(negedge clk);
    expQ.push_back('{data: d, irq: irq});
    tagQ.push_back(tag);
    regAddr = a; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slowEn = 1'b1;
      @(negedge clk); slowEn = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(0, 0, 0, "R1 ctrl");
    rd(1, 0, 0, "R1 reload");
    rd(2, 0, 0, "R1 live");
    rd(3, 0, 0, "R1 status");
    // R3 no start with zero reload
    wr(0, 32'h001); wr(0, 32'h101); slow(2);
    rd(2, 0, 0, "R3 zero reload");
    wr(0, 32'h000);
    // R5 reload acceptance
    wr(1, 2);  rd(1, 0, 0, "R5 reject 2");
    wr(1, 1);  rd(1, 0, 0, "R5 reject 1");
    wr(1, 3);  rd(1, 3, 0, "R5 accept 3");
    wr(1, 5);  rd(1, 5, 0, "R5 accept 5");
    // R10 tick enable already set
    wr(0, 32'h100); slow(3);
    rd(2, 0, 0, "R3 block off");
    wr(0, 32'h101); slow(3);
    rd(2, 0, 0, "R10 no rise");
    // R3 proper start
    wr(0, 32'h001); wr(0, 32'h101);
    rd(2, 5, 0, "R3 start");
    rd(0, 32'h101, 0, "R8 ctrl readback");
    wr(2, 32'h9);
    rd(2, 5, 0, "R8 write ignored");
    // R2 divide by 1
    slow(1); rd(2, 4, 0, "R2 sel0 step");
    slow(3); rd(2, 1, 0, "R2 sel0 steps");
    // R6 expiry
    slow(1);
    rd(2, 5, 1, "R6 reload");
    rd(3, 1, 1, "R6 status");
    // R7 clear
    wr(3, 0); rd(3, 1, 1, "R7 zero write");
    wr(3, 1); rd(3, 0, 0, "R7 clear");
    // R4 stop via tick enable, then restart with N=2
    wr(0, 32'h021); slow(2);
    rd(2, 5, 0, "R4 tick off holds");
    wr(0, 32'h121);
    slow(3); rd(2, 5, 0, "R2 sel2 wait");
    slow(1); rd(2, 4, 0, "R2 sel2 step");
    slow(4); rd(2, 3, 0, "R2 sel2 period");
    // R9 rate change keeps count
    wr(0, 32'h101); rd(2, 3, 0, "R9 kept");
    slow(1); rd(2, 2, 0, "R9 new rate");
    // R4 stop via block enable
    wr(0, 32'h100); slow(5);
    rd(2, 2, 0, "R4 block off holds");
    // R6 periodic with reload 3
    wr(1, 3); wr(0, 32'h001); wr(0, 32'h101);
    rd(2, 3, 0, "R6 restart");
    slow(2); rd(2, 1, 0, "R6 before expiry");
    slow(1); rd(2, 3, 1, "R6 first expiry");
    wr(3, 1); rd(3, 0, 0, "R7 clear again");
    slow(2); rd(2, 1, 0, "R6 second count");
    slow(1); rd(3, 1, 1, "R6 second expiry");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule